// File: doc/BRIEF.md
# NAND Bank Select and Strobe Decoder

This block puts a set of external NAND banks behind a small memory-mapped bus. One control register holds, for every bank, a bit that lets the controller drive that bank's chip-select pin and a second bit that pulls the chip select active. A bank is selected only while both of its bits are set. Software picks a bank and asserts its chip select, then issues byte accesses into that bank's address window. The offset of each access inside the window sets the NAND cycle type: at the window base it is a plain data transfer, at one offset it latches a command (CLE high), and at another it latches an address (ALE high).

Every NAND cycle waits for the ready input to be high. The block then pulls the write or read strobe low for a parameterised number of clocks and returns it high for another parameterised number of clocks. After that it completes the bus handshake with a one-cycle acknowledge. Reads capture the NAND data bus in the last clock of the low strobe. Register accesses complete without touching the NAND pins.

Address map, with `W = 1 + log2(NUM_BANKS) + 18`:

- When the top address bit is 0, the access goes to register space. The control register sits at offset 0x50, and every other offset reads as zero.
- When the top address bit is 1, the access goes to a bank window. The next log2(NUM_BANKS) bits pick the bank, and the low 18 bits are the offset inside the window.

Top module: `nbk_top`

## Requirements
- R1: After a synchronous reset, the following hold:
  - the control register is zero;
  - every `nand_ce_n` is 1 and every `nand_ce_oe` is 0;
  - `nand_we_n` and `nand_re_n` are 1;
  - `nand_cle`, `nand_ale`, `nand_dq_oe` and `cpu_ack` are 0.
- R2: A write to register offset 0x50 loads `cpu_wdata[2*NUM_BANKS-1:0]` into the control register. A read of that offset returns the current value with all higher bits zero. Writes to any other register offset change nothing, and reads of any other offset return zero.
- R3: Control bit 2x enables bank x and bit 2x+1 asserts its chip select. `nand_ce_n[x]` is 0 exactly when both bits are 1.
- R4: `nand_ce_oe[x]` (the controller drives the pin) equals the enable bit 2x.
- R5: Rewriting the control value with the odd-position (assert) bits cleared, i.e. ANDed with ~0xAA for four banks, releases every chip select and leaves the drive enables as they were.
- R6: Writing zero to the control register releases and disables every bank.
- R7: A write at window offset 0x08000 is a command cycle. `nand_cle` is 1, `nand_ale` is 0, and `nand_dq_o` carries `cpu_wdata[7:0]` with `nand_dq_oe` high.
- R8: A write at window offset 0x10000 is an address cycle with `nand_ale` 1 and `nand_cle` 0. When both offset bits 16 and 15 are set, the cycle is an address cycle. CLE and ALE are never high together.
- R9: A write at the window base is a data cycle with neither CLE nor ALE high.
- R10: Every NAND cycle holds its strobe low for exactly STROBE_CYC clocks. The strobe is `nand_we_n` for writes and `nand_re_n` for reads. It then stays high for HOLD_CYC clocks, after which `cpu_ack` is high for one clock. The two strobes are never low together.
- R11: A read at the window base is a data cycle on `nand_re_n`. The returned `cpu_rdata` equals `nand_dq_i` as sampled in the last low-strobe clock, zero-extended, and `nand_dq_oe` stays 0.
- R12: While `nand_rdy` is 0, an accepted window access does not start its strobe and does not acknowledge.
- R13: An access to the window of a bank whose enable bit is clear produces no strobe, acknowledges, and reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, held until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address (region, bank, window offset) |
| cpu_wdata | input | BUS_W | Write data |
| cpu_rdata | output | BUS_W | Read data, valid while `cpu_ack` is high |
| cpu_ack | output | 1 | One-cycle completion pulse |
| nand_ce_n | output | NUM_BANKS | Per-bank chip select, active low |
| nand_ce_oe | output | NUM_BANKS | Per-bank chip-select drive enable |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | NAND data bus, outgoing value |
| nand_dq_oe | output | 1 | NAND data bus drive enable |
| nand_dq_i | input | 8 | NAND data bus, incoming value |
| nand_rdy | input | 1 | NAND ready (1 = ready) |

## Verification
The bench builds the block with four banks, STROBE_CYC = 3 and HOLD_CYC = 2. These values differ from the defaults and from each other, so a swapped or off-by-one counter shows up as a wrong low or high length. Four banks fill all eight control bits, which makes the 0xAA assert mask and the full-width readback meaningful. Two banks stay disabled, so the disabled-window path can be exercised while the others carry traffic.

// File: rtl/nbk_pkg.sv
package nbk_pkg;

    localparam int WIN_OFS_W = 18;
    localparam int CMD_BIT   = 15;
    localparam int ADR_BIT   = 16;
    localparam int CTRL_OFS  = 'h50;

    typedef enum logic [1:0] {
        CYC_DATA = 2'd0,
        CYC_CMD  = 2'd1,
        CYC_ADDR = 2'd2
    } cyc_kind_t;

    typedef enum logic [2:0] {
        SQ_IDLE   = 3'd0,
        SQ_WAIT   = 3'd1,
        SQ_STROBE = 3'd2,
        SQ_HOLD   = 3'd3,
        SQ_DONE   = 3'd4
    } sq_state_t;

    typedef struct packed {
        logic      is_win;
        logic      hit_ctrl;
        logic      bank_on;
        cyc_kind_t kind;
    } acc_t;

    function automatic cyc_kind_t kind_of(input logic [WIN_OFS_W-1:0] ofs);
        if (ofs[ADR_BIT])
            return CYC_ADDR;
        else if (ofs[CMD_BIT])
            return CYC_CMD;
        else
            return CYC_DATA;
    endfunction

endpackage

// File: rtl/nbk_ctrl_reg.sv
module nbk_ctrl_reg #(
    parameter int NUM_BANKS = 4,
    localparam int CTRL_W = 2 * NUM_BANKS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic [CTRL_W-1:0]    wdata,
    output logic [CTRL_W-1:0]    ctrl_q,
    output logic [NUM_BANKS-1:0] bank_en,
    output logic [NUM_BANKS-1:0] ce_n,
    output logic [NUM_BANKS-1:0] ce_oe
);

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (wr)
            ctrl_q <= wdata;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic en_b, as_b;
        assign en_b       = ctrl_q[2*b];
        assign as_b       = ctrl_q[2*b+1];
        assign bank_en[b] = en_b;
        assign ce_oe[b]   = en_b;
        assign ce_n[b]    = ~(en_b & as_b);
    end

    p_wr_loads_r2: assert property (@(posedge clk) disable iff (rst)
        wr |=> ctrl_q == $past(wdata));

    p_zero_releases_r6: assert property (@(posedge clk) disable iff (rst)
        (wr && wdata == '0) |=> (ce_oe == '0 && &ce_n));

endmodule

// File: rtl/nbk_addr_decode.sv
module nbk_addr_decode
    import nbk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W = 1 + BANK_W + WIN_OFS_W
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_BANKS-1:0] bank_en,
    output acc_t                 acc
);

    logic [BANK_W-1:0]    bank_idx;
    logic [WIN_OFS_W-1:0] win_ofs;
    logic                 on;

    assign bank_idx = addr[WIN_OFS_W +: BANK_W];
    assign win_ofs  = addr[WIN_OFS_W-1:0];

    always_comb begin
        on = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++)
            if (bank_idx == BANK_W'(b) && bank_en[b])
                on = 1'b1;
    end

    always_comb begin
        acc.is_win   = addr[ADDR_W-1];
        acc.hit_ctrl = !addr[ADDR_W-1] && (addr[ADDR_W-2:0] == (ADDR_W-1)'(CTRL_OFS));
        acc.bank_on  = addr[ADDR_W-1] && on;
        acc.kind     = kind_of(win_ofs);
    end

endmodule

// File: rtl/nbk_seq.sv
module nbk_seq
    import nbk_pkg::*;
#(
    parameter int STROBE_CYC = 2,
    parameter int HOLD_CYC   = 1,
    parameter int BUS_W      = 32,
    localparam int CNT_MAX   = (STROBE_CYC > HOLD_CYC) ? STROBE_CYC : HOLD_CYC,
    localparam int CNT_W     = $clog2(CNT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             we,
    input  acc_t             acc,
    input  logic [7:0]       wbyte,
    input  logic [BUS_W-1:0] reg_rdval,
    input  logic             rdy,
    input  logic [7:0]       dq_i,
    output logic             reg_wr,
    output logic [BUS_W-1:0] rdata,
    output logic             ack,
    output logic             we_n,
    output logic             re_n,
    output logic             cle,
    output logic             ale,
    output logic [7:0]       dq_o,
    output logic             dq_oe
);

    sq_state_t  state;
    cyc_kind_t  kind_q;
    logic       wr_q;
    logic [CNT_W-1:0] cnt;
    logic       active;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            kind_q <= CYC_DATA;
            wr_q   <= 1'b0;
            cnt    <= '0;
            rdata  <= '0;
            dq_o   <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (req) begin
                        if (acc.is_win && acc.bank_on) begin
                            state  <= SQ_WAIT;
                            kind_q <= acc.kind;
                            wr_q   <= we;
                            dq_o   <= wbyte;
                            rdata  <= '0;
                        end else begin
                            state <= SQ_DONE;
                            rdata <= (!we && !acc.is_win) ? reg_rdval : '0;
                        end
                    end
                end
                SQ_WAIT: begin
                    if (rdy) begin
                        state <= SQ_STROBE;
                        cnt   <= CNT_W'(STROBE_CYC - 1);
                    end
                end
                SQ_STROBE: begin
                    if (cnt == '0) begin
                        state <= SQ_HOLD;
                        cnt   <= CNT_W'(HOLD_CYC - 1);
                        if (!wr_q)
                            rdata <= BUS_W'(dq_i);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SQ_HOLD: begin
                    if (cnt == '0)
                        state <= SQ_DONE;
                    else
                        cnt <= cnt - 1'b1;
                end
                SQ_DONE: state <= SQ_IDLE;
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign reg_wr = (state == SQ_IDLE) && req && we && acc.hit_ctrl;
    assign ack    = (state == SQ_DONE);
    assign active = (state == SQ_STROBE) || (state == SQ_HOLD);
    assign we_n   = !((state == SQ_STROBE) && wr_q);
    assign re_n   = !((state == SQ_STROBE) && !wr_q);
    assign cle    = active && (kind_q == CYC_CMD);
    assign ale    = active && (kind_q == CYC_ADDR);
    assign dq_oe  = active && wr_q;

    // Low-run counter for the strobe-length check
    logic       strobe_n;
    logic [7:0] low_run;
    assign strobe_n = we_n & re_n;
    always_ff @(posedge clk) begin
        if (rst)
            low_run <= '0;
        else if (!strobe_n)
            low_run <= low_run + 1'b1;
        else
            low_run <= '0;
    end

    p_strobe_len_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe_n) |-> low_run == 8'(STROBE_CYC));

    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !re_n));

    p_ack_single_r10: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    p_cle_ale_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(cle && ale));

    p_write_drives_r7: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> dq_oe);

    p_wait_ready_r12: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_WAIT && !rdy) |=> (state == SQ_WAIT && strobe_n));

endmodule

// File: rtl/nbk_top.sv
module nbk_top
    import nbk_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int STROBE_CYC = 2,
    parameter int HOLD_CYC   = 1,
    parameter int BUS_W      = 32,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W = 1 + BANK_W + WIN_OFS_W,
    localparam int CTRL_W = 2 * NUM_BANKS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cpu_req,
    input  logic                 cpu_we,
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic [BUS_W-1:0]     cpu_wdata,
    output logic [BUS_W-1:0]     cpu_rdata,
    output logic                 cpu_ack,
    output logic [NUM_BANKS-1:0] nand_ce_n,
    output logic [NUM_BANKS-1:0] nand_ce_oe,
    output logic                 nand_cle,
    output logic                 nand_ale,
    output logic                 nand_we_n,
    output logic                 nand_re_n,
    output logic [7:0]           nand_dq_o,
    output logic                 nand_dq_oe,
    input  logic [7:0]           nand_dq_i,
    input  logic                 nand_rdy
);

    logic [CTRL_W-1:0]    ctrl_q;
    logic [NUM_BANKS-1:0] bank_en;
    logic                 reg_wr;
    logic [BUS_W-1:0]     reg_rdval;
    acc_t                 acc;
    logic                 unused_wdata;

    assign unused_wdata = ^cpu_wdata;

    nbk_ctrl_reg #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr      (reg_wr),
        .wdata   (cpu_wdata[CTRL_W-1:0]),
        .ctrl_q  (ctrl_q),
        .bank_en (bank_en),
        .ce_n    (nand_ce_n),
        .ce_oe   (nand_ce_oe)
    );

    nbk_addr_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
        .addr    (cpu_addr),
        .bank_en (bank_en),
        .acc     (acc)
    );

    assign reg_rdval = acc.hit_ctrl ? BUS_W'(ctrl_q) : '0;

    nbk_seq #(
        .STROBE_CYC (STROBE_CYC),
        .HOLD_CYC   (HOLD_CYC),
        .BUS_W      (BUS_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (cpu_req),
        .we        (cpu_we),
        .acc       (acc),
        .wbyte     (cpu_wdata[7:0]),
        .reg_rdval (reg_rdval),
        .rdy       (nand_rdy),
        .dq_i      (nand_dq_i),
        .reg_wr    (reg_wr),
        .rdata     (cpu_rdata),
        .ack       (cpu_ack),
        .we_n      (nand_we_n),
        .re_n      (nand_re_n),
        .cle       (nand_cle),
        .ale       (nand_ale),
        .dq_o      (nand_dq_o),
        .dq_oe     (nand_dq_oe)
    );

endmodule

// File: tb/nbk_top_bench.sv
module nbk_top_bench;

    localparam int NB  = 4;
    localparam int STB = 3;
    localparam int HLD = 2;
    localparam int AW  = 21;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_req = 1'b0;
    logic          cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [31:0]   cpu_wdata = '0;
    logic [31:0]   cpu_rdata;
    logic          cpu_ack;
    logic [NB-1:0] nand_ce_n, nand_ce_oe;
    logic          nand_cle, nand_ale, nand_we_n, nand_re_n;
    logic [7:0]    nand_dq_o;
    logic          nand_dq_oe;
    logic [7:0]    nand_dq_i = '0;
    logic          nand_rdy = 1'b1;

    always #2 clk = ~clk;

    nbk_top #(.NUM_BANKS(NB), .STROBE_CYC(STB), .HOLD_CYC(HLD), .BUS_W(32)) u_nbk_top (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ack(cpu_ack), .nand_ce_n(nand_ce_n), .nand_ce_oe(nand_ce_oe),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe),
        .nand_dq_i(nand_dq_i), .nand_rdy(nand_rdy)
    );

    typedef struct {
        logic [31:0] rdata;
        int          wlo;
        int          rlo;
        int          hold;
        bit          cle;
        bit          ale;
        logic [7:0]  dq;
    } exp_t;

    exp_t  expq[$];
    string tagq[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: measure each transaction, compare on acknowledge
    int         m_wlo = 0, m_rlo = 0, m_hold = 0;
    bit         m_seen = 0, m_cle = 0, m_ale = 0;
    logic [7:0] m_dq = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!nand_we_n) m_wlo++;
            if (!nand_re_n) m_rlo++;
            if (!nand_we_n || !nand_re_n) begin
                m_seen = 1;
                m_cle |= nand_cle;
                m_ale |= nand_ale;
                if (nand_dq_oe) m_dq = nand_dq_o;
            end else if (m_seen && !cpu_ack) begin
                m_hold++;
            end
            if (cpu_ack) begin
                n_chk++;
                if (expq.size() == 0) begin
                    n_bad++;
                    $display("FAIL unexpected acknowledge: actual 1 expected 0");
                end else begin
                    exp_t  e;
                    string t;
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    if (cpu_rdata !== e.rdata || m_wlo != e.wlo || m_rlo != e.rlo ||
                        m_hold != e.hold || m_cle != e.cle || m_ale != e.ale || m_dq !== e.dq) begin
                        n_bad++;
                        $display("FAIL %s: actual rd=%h wlo=%0d rlo=%0d hold=%0d cle=%0d ale=%0d dq=%h expected rd=%h wlo=%0d rlo=%0d hold=%0d cle=%0d ale=%0d dq=%h",
                            t, cpu_rdata, m_wlo, m_rlo, m_hold, m_cle, m_ale, m_dq,
                            e.rdata, e.wlo, e.rlo, e.hold, e.cle, e.ale, e.dq);
                    end
                end
                m_wlo = 0; m_rlo = 0; m_hold = 0;
                m_seen = 0; m_cle = 0; m_ale = 0; m_dq = '0;
            end
        end
    end

    task automatic bus(string tag, logic [AW-1:0] a, logic w, logic [31:0] d,
                       logic [7:0] dqi, exp_t e);
        @(negedge clk);
        expq.push_back(e);
        tagq.push_back(tag);
        cpu_addr  = a;
        cpu_we    = w;
        cpu_wdata = d;
        nand_dq_i = dqi;
        cpu_req   = 1'b1;
        do @(negedge clk); while (!cpu_ack);
        cpu_req = 1'b0;
    endtask

    function automatic exp_t plain(logic [31:0] rd);
        exp_t e;
        e.rdata = rd; e.wlo = 0; e.rlo = 0; e.hold = 0;
        e.cle = 0; e.ale = 0; e.dq = '0;
        return e;
    endfunction

    task automatic reg_wr(string tag, int ofs, logic [31:0] v);
        bus(tag, AW'(ofs), 1'b1, v, 8'h00, plain('0));
    endtask

    task automatic reg_rd(string tag, int ofs, logic [31:0] exp);
        bus(tag, AW'(ofs), 1'b0, '0, 8'h00, plain(exp));
    endtask

    function automatic logic [AW-1:0] win(int bank, int ofs);
        return AW'((1 << 20) | (bank << 18) | ofs);
    endfunction

    task automatic nd_wr(string tag, int bank, int ofs, logic [7:0] d,
                         bit cle, bit ale, bit on);
        exp_t e;
        e = plain('0);
        if (on) begin
            e.wlo = STB; e.hold = HLD; e.cle = cle; e.ale = ale; e.dq = d;
        end
        bus(tag, win(bank, ofs), 1'b1, {24'hC0FFEE, d}, 8'h00, e);
    endtask

    task automatic nd_rd(string tag, int bank, logic [7:0] dqi, bit on);
        exp_t e;
        e = plain('0);
        if (on) begin
            e.rlo = STB; e.hold = HLD; e.rdata = {24'h0, dqi};
        end
        bus(tag, win(bank, 0), 1'b0, '0, dqi, e);
    endtask

    // Watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ce_n",  32'(nand_ce_n), 32'hF);
        chk("R1 ce_oe", 32'(nand_ce_oe), 32'h0);
        chk("R1 strobes", {30'h0, nand_we_n, nand_re_n}, 32'h3);
        chk("R1 latches", {29'h0, nand_cle, nand_ale, nand_dq_oe}, 32'h0);
        chk("R1 ack", 32'(cpu_ack), 32'h0);
        reg_rd("R1 ctrl read", 'h50, 32'h0);

        // R4 enables only
        reg_wr("R4 write 55", 'h50, 32'h55);
        chk("R4 ce_oe all", 32'(nand_ce_oe), 32'hF);
        chk("R3 enabled but not asserted", 32'(nand_ce_n), 32'hF);

        // R3 full assert, R2 readback
        reg_wr("R3 write FF", 'h50, 32'hFF);
        chk("R3 all selected", 32'(nand_ce_n), 32'h0);
        reg_wr("R2 write upper junk", 'h50, 32'h1234_560F);
        reg_rd("R2 read upper zero", 'h50, 32'h0000_000F);
        chk("R3 banks0-1 selected", 32'(nand_ce_n), 32'hC);
        chk("R4 banks0-1 driven", 32'(nand_ce_oe), 32'h3);

        // R2 other offsets ignored
        reg_wr("R2 write other offset", 'h54, 32'h0);
        reg_rd("R2 ctrl unchanged", 'h50, 32'h0000_000F);
        reg_rd("R2 other offset reads 0", 'h54, 32'h0);
        chk("R2 pins unchanged", 32'(nand_ce_n), 32'hC);

        // R7 command, R8 address, R9 data, R11 read
        nd_wr("R7 command cycle", 0, 'h08000, 8'h70, 1, 0, 1);
        nd_wr("R8 address cycle", 1, 'h10000, 8'h3C, 0, 1, 1);
        nd_wr("R8 both bits -> address", 0, 'h18000, 8'h81, 0, 1, 1);
        nd_wr("R9 data write", 0, 'h00000, 8'hA5, 0, 0, 1);
        nd_rd("R11 data read", 1, 8'h5A, 1);
        nd_rd("R11 second read", 0, 8'hC3, 1);
        // R10 timing across kinds is checked per item (wlo/rlo/hold)
        nd_wr("R10 data write timing", 1, 'h00004, 8'h0F, 0, 0, 1);

        // R13 disabled banks
        nd_wr("R13 disabled write", 2, 'h08000, 8'hEE, 0, 0, 0);
        nd_rd("R13 disabled read", 3, 8'h77, 0);

        // R12 ready low holds the cycle
        nand_rdy = 1'b0;
        fork
            nd_wr("R12 delayed command", 1, 'h08000, 8'hFF, 1, 0, 1);
            begin
                repeat (8) @(negedge clk);
                chk("R12 no strobe while busy", {30'h0, nand_we_n, cpu_ack}, 32'h2);
                nand_rdy = 1'b1;
            end
        join

        // R5 release all chip selects, keep enables
        reg_wr("R5 clear assert bits", 'h50, 32'h0F & ~32'hAA);
        chk("R5 all released", 32'(nand_ce_n), 32'hF);
        chk("R5 enables kept", 32'(nand_ce_oe), 32'h3);

        // R6 zero disables all
        reg_wr("R6 write FF", 'h50, 32'hFF);
        reg_wr("R6 write zero", 'h50, 32'h0);
        chk("R6 all released", 32'(nand_ce_n), 32'hF);
        chk("R6 all undriven", 32'(nand_ce_oe), 32'h0);
        nd_rd("R6 bank now disabled", 0, 8'h99, 0);

        repeat (4) @(negedge clk);
        chk("queue drained", 32'(expq.size()), 32'h0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule